// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Two-Entry Character Queue

This block receives characters from one asynchronous serial line. A sampling pulse arrives at sixteen times the bit rate. While the line is idle, the block waits for a falling edge. It confirms the start bit near the middle of that bit, then samples each data bit near its middle using a three-sample majority vote. Finally it checks the stop level. Each finished character is written into a small queue together with its own framing flag. The consumer takes characters from the head of the queue with a one-cycle read strobe.

Characters carry 8 or 9 data bits, chosen by a mode input. Reception runs only when the receive enable and the port enable are both set and the synchronous-mode select is low. If a character completes while the queue is full and nothing is read in that cycle, an overflow flag is set. Reception then stops until software clears the flag.

Top module: `osr_uart_rx`

## Requirements
- R1: A character starts on a falling edge of the synchronized line while idle. If the majority of samples 7, 8 and 9 (counted from the edge tick as 0) is high, the start is abandoned: no character is stored and no flag changes. The block then looks for a new falling edge.
- R2: Each data bit and the stop bit take the majority of the three samples at ticks 7, 8 and 9 of the bit, so a line inversion lasting a single tick inside that window does not change the result.
- R3: Data bits arrive least significant bit first. In 8-bit mode (`nine_bit_i`=0) the character appears on `head_data_o[7:0]` and `head_data_o[8]` is 0.
- R4: In 9-bit mode (`nine_bit_i`=1) all nine bits appear on `head_data_o[8:0]`, with the first received bit at bit 0.
- R5: A low stop sample stores the character with `head_ferr_o`=1. A high stop sample stores it with `head_ferr_o`=0. The flag travels with its own character through the queue.
- R6: The queue holds two characters in arrival order. `avail_o` is high exactly while at least one character is stored. A `rd_i` pulse removes the head, and the change is visible after the next clock edge.
- R7: `rd_i` on an empty queue has no effect: `avail_o` stays low and the next character is delivered intact.
- R8: A character that completes with the queue full and no read in the same cycle is discarded and sets `overrun_o`. While `overrun_o` is high, no further character is received, even after the queue drains. A `ovr_clr_i` pulse clears the flag and reception resumes.
- R9: Reception is active only when `rx_en_i`=1, `port_en_i`=1 and `sync_mode_i`=0. While inactive, line activity is ignored, the queue is emptied, `overrun_o` is cleared and the receiver returns to idle.
- R10: After reset, `avail_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en_i | input | 1 | Receive enable |
| port_en_i | input | 1 | Port enable |
| sync_mode_i | input | 1 | 1 selects synchronous mode, which disables this receiver |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rd_i | input | 1 | Pops the head character |
| ovr_clr_i | input | 1 | Clears the overflow flag |
| head_data_o | output | 9 | Head character data |
| head_ferr_o | output | 1 | Framing flag of the head character |
| avail_o | output | 1 | At least one character is stored |
| overrun_o | output | 1 | Overflow flag |

## Verification
A character is written into the queue at the tick that takes the middle stop sample. That is about ten ticks into the stop bit, plus two clocks of synchronizer delay. The bench therefore updates its reference queue only after it has driven the whole stop bit and a further idle bit, and it suspends the per-clock comparison while a frame is on the line. Reads, overflow clears and enable changes take effect at the next clock edge. For these, the bench drives the input at a falling clock edge, updates the model one clock later, and compares again from the following falling edge. Line changes are aligned just after a tick, so a single-tick glitch placed mid-bit lands on exactly one of the three votes.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

  localparam int MAX_BITS = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic                ferr;
    logic [MAX_BITS-1:0] data;
  } rx_char_t;

endpackage

// File: rtl/osr_rx_sync.sv
module osr_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/osr_rx_core.sv
module osr_rx_core
  import osr_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int SAMPLE_MID = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active_i,
  input  logic     hold_i,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     nine_i,
  output logic     push_o,
  output rx_char_t char_o
);

  localparam int CW     = $clog2(OSR);
  localparam int BW     = $clog2(MAX_BITS + 1);
  localparam int SMP_LO = SAMPLE_MID - 1;
  localparam int SMP_HI = SAMPLE_MID + 1;

  rx_state_e           state_q, state_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [BW-1:0]       bit_q, bit_d;
  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic [1:0]          smp_q, smp_d;
  logic                last_q, last_d;
  logic                maj;
  logic [BW-1:0]       last_idx;
  logic                at_hi, at_end;

  assign maj      = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx_i) | (smp_q[0] & rx_i);
  assign last_idx = nine_i ? BW'(MAX_BITS - 1) : BW'(MAX_BITS - 2);
  assign at_hi    = (cnt_q == CW'(SMP_HI));
  assign at_end   = (cnt_q == CW'(OSR - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    smp_d   = smp_q;
    last_d  = last_q;
    push_o  = 1'b0;
    if (!active_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      bit_d   = '0;
      last_d  = 1'b1;
    end else if (tick_i) begin
      last_d = rx_i;
      if (cnt_q == CW'(SMP_LO) || cnt_q == CW'(SAMPLE_MID))
        smp_d = {smp_q[0], rx_i};
      unique case (state_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (!hold_i && last_q && !rx_i) begin
            state_d = ST_START;
            cnt_d   = CW'(1);
          end
        end
        ST_START: begin
          cnt_d = cnt_q + CW'(1);
          if (at_hi && maj) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else if (at_end) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            bit_d   = '0;
          end
        end
        ST_DATA: begin
          cnt_d = cnt_q + CW'(1);
          if (at_hi) sh_d = {maj, sh_q[MAX_BITS-1:1]};
          if (at_end) begin
            cnt_d = '0;
            if (bit_q == last_idx) state_d = ST_STOP;
            else                   bit_d   = bit_q + BW'(1);
          end
        end
        ST_STOP: begin
          cnt_d = cnt_q + CW'(1);
          if (at_hi) begin
            push_o  = ~hold_i;
            state_d = ST_IDLE;
            cnt_d   = '0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign char_o.ferr = ~maj;
  assign char_o.data = nine_i ? sh_q : {1'b0, sh_q[MAX_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      smp_q   <= 2'b11;
      last_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      smp_q   <= smp_d;
      last_q  <= last_d;
    end
  end

  // R1
  state_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && active_i) |=> $stable(state_q));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && active_i && state_q == ST_IDLE) |=> (state_q == ST_IDLE));

  // R9
  inactive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (state_q == ST_IDLE));

endmodule

// File: rtl/osr_rx_fifo.sv
module osr_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  input  logic         ovr_clr_i,
  output logic [W-1:0] dout_o,
  output logic         avail_o,
  output logic         ovr_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic          full, pop_ok, wr_en, ovf;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full   = (cnt_q == NW'(DEPTH));
  assign pop_ok = pop_i && (cnt_q != '0);
  assign wr_en  = push_i && !ovr_q && (!full || pop_ok);
  assign ovf    = push_i && !ovr_q && full && !pop_ok;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    ovr_d = ovr_q;
    if (clr_i) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
      ovr_d = 1'b0;
    end else begin
      if (pop_ok) rd_d = nxt(rd_q);
      if (wr_en)  wr_d = nxt(wr_q);
      if (wr_en && !pop_ok)      cnt_d = cnt_q + NW'(1);
      else if (!wr_en && pop_ok) cnt_d = cnt_q - NW'(1);
      if (ovf)            ovr_d = 1'b1;
      else if (ovr_clr_i) ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr_i) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign avail_o = (cnt_q != '0);
  assign ovr_o   = ovr_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NW'(DEPTH));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q == '0 && !push_i && !clr_i) |=> (cnt_q == '0));

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i && !clr_i) |=> (ovr_q && $stable(cnt_q)));

  // R9
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && !ovr_q));

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SAMPLE_MID  = 8,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_i,
  input  logic                tick16_i,
  input  logic                rx_en_i,
  input  logic                port_en_i,
  input  logic                sync_mode_i,
  input  logic                nine_bit_i,
  input  logic                rd_i,
  input  logic                ovr_clr_i,
  output logic [MAX_BITS-1:0] head_data_o,
  output logic                head_ferr_o,
  output logic                avail_o,
  output logic                overrun_o
);

  localparam int CHW = $bits(rx_char_t);

  logic     rst_meta_q, rst_sync_q;
  logic     rx_s, active, push;
  rx_char_t char_in, char_head;
  logic     ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign active = rx_en_i & port_en_i & ~sync_mode_i;

  osr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  osr_rx_core #(.OSR(OSR), .SAMPLE_MID(SAMPLE_MID)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .active_i (active),
    .hold_i   (ovr),
    .tick_i   (tick16_i),
    .rx_i     (rx_s),
    .nine_i   (nine_bit_i),
    .push_o   (push),
    .char_o   (char_in)
  );

  osr_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .clr_i     (~active),
    .push_i    (push),
    .din_i     (char_in),
    .pop_i     (rd_i),
    .ovr_clr_i (ovr_clr_i),
    .dout_o    (char_head),
    .avail_o   (avail_o),
    .ovr_o     (ovr)
  );

  assign head_data_o = char_head.data;
  assign head_ferr_o = char_head.ferr;
  assign overrun_o   = ovr;

  // R9
  inactive_out_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !active |=> (!avail_o && !overrun_o));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (overrun_o && active && !ovr_clr_i) |=> overrun_o);

endmodule

// File: tb/sim_osr_uart_rx.sv
module sim_osr_uart_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       rx_en = 1'b0, port_en = 1'b0, sync_mode = 1'b0, nine = 1'b0;
  logic       rd = 1'b0, ovr_clr = 1'b0;
  logic [8:0] head_data;
  logic       head_ferr, avail, overrun;
  logic [1:0] tcnt = 2'd0;
  logic       tick16;

  int         nchk = 0, nerr = 0;
  bit         cmp_en = 1'b0;
  bit [9:0]   mq[$];
  bit         ovr_m = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign tick16 = (tcnt == 2'd3);

  osr_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick16_i(tick16),
    .rx_en_i(rx_en), .port_en_i(port_en), .sync_mode_i(sync_mode),
    .nine_bit_i(nine), .rd_i(rd), .ovr_clr_i(ovr_clr),
    .head_data_o(head_data), .head_ferr_o(head_ferr),
    .avail_o(avail), .overrun_o(overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_model(input string req);
    check(avail == (mq.size() != 0), req, "avail", int'(avail), int'(mq.size() != 0));
    check(overrun == ovr_m, req, "overrun", int'(overrun), int'(ovr_m));
    if (mq.size() != 0) begin
      check(head_data == mq[0][8:0], req, "head_data", int'(head_data), int'(mq[0][8:0]));
      check(head_ferr == mq[0][9], req, "head_ferr", int'(head_ferr), int'(mq[0][9]));
    end
  endtask

  // per-clock comparison against the reference queue (R6)
  always @(negedge clk) if (cmp_en && !done) cmp_model("R6");

  function automatic bit active_m();
    return rx_en && port_en && !sync_mode;
  endfunction

  task automatic align();
    do @(negedge clk); while (tcnt != 2'd0);
  endtask

  task automatic send(input bit [8:0] d, input int nb, input bit stopv, input int gbit);
    cmp_en = 1'b0;
    align();
    rx = 1'b0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx = d[i];
      if (i == gbit) begin
        repeat (32) @(negedge clk);
        rx = ~d[i];
        repeat (4) @(negedge clk);
        rx = d[i];
        repeat (28) @(negedge clk);
      end else begin
        repeat (64) @(negedge clk);
      end
    end
    rx = stopv;
    repeat (64) @(negedge clk);
    rx = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  task automatic frame(input bit [8:0] d, input bit stopv, input int gbit);
    int nb;
    bit [8:0] v;
    nb = nine ? 9 : 8;
    v  = nine ? d : {1'b0, d[7:0]};
    send(d, nb, stopv, gbit);
    if (active_m() && !ovr_m) begin
      if (mq.size() == 2) ovr_m = 1'b1;
      else mq.push_back({~stopv, v});
    end
    cmp_en = 1'b1;
  endtask

  task automatic read();
    cmp_en = 1'b0;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    if (mq.size() != 0) void'(mq.pop_front());
    @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic set_ctrl(input bit en, input bit pen, input bit sm);
    cmp_en = 1'b0;
    rx_en = en; port_en = pen; sync_mode = sm;
    @(negedge clk);
    if (!active_m()) begin
      mq.delete();
      ovr_m = 1'b0;
    end
    @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(avail == 1'b0, "R10", "avail", int'(avail), 0);
    check(overrun == 1'b0, "R10", "overrun", int'(overrun), 0);

    set_ctrl(1, 1, 0);

    // R3 8-bit, LSB first
    frame(9'h0A5, 1'b1, -1);
    check(avail && head_data == 9'h0A5, "R3", "head_data", int'(head_data), 'h0A5);
    read();
    check(!avail, "R6", "avail after read", int'(avail), 0);

    // R1 false start: low only 3 ticks
    cmp_en = 1'b0;
    align();
    rx = 1'b0;
    repeat (12) @(negedge clk);
    rx = 1'b1;
    repeat (1200) @(negedge clk);
    check(!avail && !overrun, "R1", "false start stored", int'(avail), 0);
    cmp_en = 1'b1;
    frame(9'h03C, 1'b1, -1);
    check(head_data == 9'h03C, "R1", "after false start", int'(head_data), 'h03C);
    read();

    // R2 single-tick glitch mid-bit
    frame(9'h05A, 1'b1, 3);
    check(head_data == 9'h05A && !head_ferr, "R2", "majority", int'(head_data), 'h05A);
    read();

    // R4 9-bit mode
    nine = 1'b1;
    frame(9'h1C3, 1'b1, -1);
    check(head_data == 9'h1C3, "R4", "nine bit data", int'(head_data), 'h1C3);
    read();
    nine = 1'b0;

    // R5 framing flag per character
    frame(9'h081, 1'b0, -1);
    frame(9'h042, 1'b1, -1);
    check(head_ferr == 1'b1 && head_data == 9'h081, "R5", "ferr first", int'(head_ferr), 1);
    read();
    check(head_ferr == 1'b0 && head_data == 9'h042, "R5", "ferr second", int'(head_ferr), 0);
    read();

    // R7 read on empty
    read();
    check(!avail, "R7", "avail after empty read", int'(avail), 0);
    frame(9'h011, 1'b1, -1);
    check(head_data == 9'h011, "R7", "data after empty read", int'(head_data), 'h011);

    // R8 overrun
    frame(9'h022, 1'b1, -1);
    frame(9'h033, 1'b1, -1);
    check(overrun == 1'b1, "R8", "overrun set", int'(overrun), 1);
    check(head_data == 9'h011, "R8", "head kept", int'(head_data), 'h011);
    frame(9'h044, 1'b1, -1);
    read();
    check(head_data == 9'h022, "R8", "second entry", int'(head_data), 'h022);
    read();
    check(!avail && overrun, "R8", "drained, still overrun", int'(overrun), 1);
    frame(9'h055, 1'b1, -1);
    check(!avail, "R8", "blocked while overrun", int'(avail), 0);
    cmp_en = 1'b0;
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    ovr_m = 1'b0;
    @(negedge clk);
    cmp_en = 1'b1;
    check(!overrun, "R8", "overrun cleared", int'(overrun), 0);
    frame(9'h066, 1'b1, -1);
    check(head_data == 9'h066, "R8", "resumed", int'(head_data), 'h066);

    // R9 enable gating
    frame(9'h077, 1'b1, -1);
    frame(9'h088, 1'b1, -1);
    check(overrun, "R9", "overrun before disable", int'(overrun), 1);
    set_ctrl(0, 1, 0);
    check(!avail && !overrun, "R9", "disable clears", int'(avail), 0);
    frame(9'h0F0, 1'b1, -1);
    check(!avail, "R9", "rx_en low ignored", int'(avail), 0);
    set_ctrl(1, 1, 1);
    frame(9'h0F1, 1'b1, -1);
    check(!avail, "R9", "sync mode ignored", int'(avail), 0);
    set_ctrl(1, 0, 0);
    frame(9'h0F2, 1'b1, -1);
    check(!avail, "R9", "port_en low ignored", int'(avail), 0);
    set_ctrl(1, 1, 0);
    frame(9'h099, 1'b1, -1);
    check(head_data == 9'h099, "R9", "re-enabled", int'(head_data), 'h099);
    read();

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule